// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This block keeps the status word of a small 16-bit processor. Whenever the ALU reports that an operation has finished, the block takes the operands, the result and the two carry signals from the ALU and records carry, parity, auxiliary carry, zero, sign and overflow. Byte operations and word operations are both supported, and the operation class (add, subtract or logic) decides how carry, auxiliary carry and overflow are formed.

The block also holds three control bits: single-step trap, interrupt enable and string direction. Only explicit set and clear commands change them. ALU results never do. The direction bit is also driven on a separate output, which the string address logic uses to choose between incrementing and decrementing its index registers. The whole word appears on one 16-bit output. Its layout is fixed and has gaps, and the unused positions always read as constants.

Top module: `status_word_unit`

## Requirements
- R1: Bit 0 (carry) takes the value of `carryOut` when an add (`opClass`=0) or subtract (`opClass`=1) completes. For subtract, `carryOut` is the borrow.
- R2: Bit 2 (parity) is 1 when the low 8 bits of `result` contain an even number of ones. This holds for byte and word operations alike.
- R3: Bit 4 (auxiliary carry) takes the value of `nibbleCarry` when an add or subtract completes.
- R4: Bit 6 (zero) is 1 when the result is all zeros. Only the low 8 bits are tested when `opWord`=0, and all 16 bits when `opWord`=1.
- R5: Bit 7 (sign) copies result bit 7 for byte operations and result bit 15 for word operations.
- R6: Bit 11 (overflow) is set when the two's-complement result of operandA+operandB (add) or operandA-operandB (subtract), taken at the selected width, does not fit in that width.
- R7: A logic operation (`opClass`=2, and also code 3) clears carry, auxiliary carry and overflow, whatever `carryOut` and `nibbleCarry` say.
- R8: Bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.
- R9: `ctlSel` selects trap (0, bit 8), interrupt enable (1, bit 9) or direction (2, bit 10). `ctlSet` sets the selected bit and `ctlClr` clears it. When both are high, set wins. Selection code 3 changes nothing.
- R10: Completing operations never changes bits 8 to 10. Control commands never change the arithmetic flags.
- R11: While `opValid` is low, the arithmetic flags keep their values whatever the data inputs do.
- R12: `stepNeg` equals the direction bit (1 means the indexes decrement, 0 means they increment).
- R13: While `rstN` is low, the status word reads 0x0002 and `stepNeg` reads 0.
- R14: An operation or command presented at a rising clock edge is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An ALU operation completes this cycle |
| opWord | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opClass | input | 2 | 0 add, 1 subtract, 2/3 logic |
| operandA | input | 16 | First ALU operand |
| operandB | input | 16 | Second ALU operand |
| result | input | 16 | ALU result |
| carryOut | input | 1 | Carry (or borrow) out of the selected width |
| nibbleCarry | input | 1 | Carry (or borrow) out of bit 3 |
| ctlSel | input | 2 | Control bit select |
| ctlSet | input | 1 | Set the selected control bit |
| ctlClr | input | 1 | Clear the selected control bit |
| statusWord | output | 16 | Assembled status word |
| stepNeg | output | 1 | 1 = string indexes decrement |

## Verification
The bench acts as the ALU. Byte adds, subtracts and logic operations are swept over every first operand against a strided set of second operands, so every parity pattern and every carry, borrow and overflow boundary is reached. For byte operations the result bus carries a nonzero upper byte. This is what separates testing zero and sign on the byte from testing them on the whole word, and it also shows that parity ignores the upper byte. Word operations use sign-boundary values such as 0x7FFF, 0x8000 and 0xFFFF, which separate overflow from carry. Logic operations are driven with both carry inputs high to prove that those inputs are masked. Control commands are mixed with operations, idle cycles and a mid-run reset, which separates the arithmetic flags from the control state.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int FLAG_W    = 16;
  localparam int POS_CARRY = 0;
  localparam int POS_ONE   = 1;
  localparam int POS_PAR   = 2;
  localparam int POS_AUX   = 4;
  localparam int POS_ZERO  = 6;
  localparam int POS_SIGN  = 7;
  localparam int POS_CTL   = 8;   // trap, interrupt, direction in ascending order
  localparam int POS_OVF   = 11;
  localparam int CTL_N     = 3;
  localparam int CTL_TRAP  = 0;
  localparam int CTL_INTR  = 1;
  localparam int CTL_DIR   = 2;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_LOGX  = 2'd3
  } opClass_e;

  typedef struct packed {
    logic             arithEn;
    logic             subOp;
    logic             logicOp;
    logic [CTL_N-1:0] ctlWe;
    logic [CTL_N-1:0] ctlVal;
  } flagStrobe_t;
endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opClass,
  input  logic [SEL_W-1:0] ctlSel,
  input  logic             ctlSet,
  input  logic             ctlClr,
  output flagStrobe_t      strb
);
  opClass_e cls;
  logic     cmdAny;

  always_comb begin
    cls          = opClass_e'(opClass);
    cmdAny       = ctlSet | ctlClr;
    strb.arithEn = opValid;
    strb.subOp   = (cls == OP_SUB);
    strb.logicOp = (cls == OP_LOGIC) || (cls == OP_LOGX);
  end

  for (genvar i = 0; i < CTL_N; i++) begin : g_sel
    always_comb begin
      strb.ctlWe[i]  = cmdAny && (ctlSel == SEL_W'(i));
      strb.ctlVal[i] = ctlSet;
    end
  end

  AST_ONE_CTL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.ctlWe)) else $error("more than one control write"); // R9
  AST_SEL3_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSel == SEL_W'(3)) |-> (strb.ctlWe == '0)) else $error("code 3 wrote"); // R9
endmodule

// File: rtl/sw_dpath.sv
module sw_dpath
  import sw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strb,
  input  logic              opWord,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  input  logic              nibbleCarry,
  output logic [FLAG_W-1:0] flagWord,
  output logic              stepNeg
);
  localparam int BYTE_W = DATA_W / 2;

  logic carryQ, parQ, auxQ, zeroQ, signQ, ovfQ;
  logic [CTL_N-1:0] ctlQ;
  logic carryD, parD, auxD, zeroD, signD, ovfD;
  logic sa, sb, sr;
  logic [BYTE_W-1:0] lowByte;
  logic parChain [BYTE_W+1];

  assign lowByte = result[BYTE_W-1:0];
  assign parChain[0] = 1'b1;
  for (genvar i = 0; i < BYTE_W; i++) begin : g_par
    assign parChain[i+1] = parChain[i] ^ lowByte[i];
  end

  always_comb begin
    sa     = opWord ? operandA[DATA_W-1] : operandA[BYTE_W-1];
    sb     = opWord ? operandB[DATA_W-1] : operandB[BYTE_W-1];
    sr     = opWord ? result[DATA_W-1]   : result[BYTE_W-1];
    zeroD  = opWord ? (result == '0) : (lowByte == '0);
    signD  = sr;
    parD   = parChain[BYTE_W];
    if (strb.logicOp) begin
      carryD = 1'b0;
      auxD   = 1'b0;
      ovfD   = 1'b0;
    end else begin
      carryD = carryOut;
      auxD   = nibbleCarry;
      ovfD   = strb.subOp ? ((sa != sb) && (sr != sa))
                          : ((sa == sb) && (sr != sa));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      parQ   <= 1'b0;
      auxQ   <= 1'b0;
      zeroQ  <= 1'b0;
      signQ  <= 1'b0;
      ovfQ   <= 1'b0;
    end else if (strb.arithEn) begin
      carryQ <= carryD;
      parQ   <= parD;
      auxQ   <= auxD;
      zeroQ  <= zeroD;
      signQ  <= signD;
      ovfQ   <= ovfD;
    end
  end

  for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               ctlQ[i] <= 1'b0;
      else if (strb.ctlWe[i])  ctlQ[i] <= strb.ctlVal[i];
    end
  end

  always_comb begin
    flagWord                          = '0;
    flagWord[POS_ONE]                 = 1'b1;
    flagWord[POS_CARRY]               = carryQ;
    flagWord[POS_PAR]                 = parQ;
    flagWord[POS_AUX]                 = auxQ;
    flagWord[POS_ZERO]                = zeroQ;
    flagWord[POS_SIGN]                = signQ;
    flagWord[POS_OVF]                 = ovfQ;
    flagWord[POS_CTL +: CTL_N]        = ctlQ;
  end
  assign stepNeg = ctlQ[CTL_DIR];

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.arithEn && strb.logicOp) |=> (!carryQ && !auxQ && !ovfQ))
    else $error("logic op left arithmetic carry"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.arithEn |=> $stable({carryQ, parQ, auxQ, zeroQ, signQ, ovfQ}))
    else $error("flags moved while idle"); // R11
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctlWe == '0) |=> $stable(ctlQ)) else $error("control bit moved"); // R10
  AST_WORD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.arithEn && opWord && (result == '0)) |=> zeroQ)
    else $error("zero missed"); // R4
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
  import sw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opWord,
  input  logic [1:0]        opClass,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  input  logic              nibbleCarry,
  input  logic [SEL_W-1:0]  ctlSel,
  input  logic              ctlSet,
  input  logic              ctlClr,
  output logic [FLAG_W-1:0] statusWord,
  output logic              stepNeg
);
  flagStrobe_t strb;

  sw_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .ctlSel(ctlSel), .ctlSet(ctlSet), .ctlClr(ctlClr), .strb(strb)
  );

  sw_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opWord(opWord),
    .operandA(operandA), .operandB(operandB), .result(result),
    .carryOut(carryOut), .nibbleCarry(nibbleCarry),
    .flagWord(statusWord), .stepNeg(stepNeg)
  );

  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSet && ctlSel == SEL_W'(CTL_DIR)) |=> stepNeg)
    else $error("direction not set"); // R12
  AST_DIR_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (ctlClr && !ctlSet && ctlSel == SEL_W'(CTL_DIR)) |=> !stepNeg)
    else $error("direction not cleared"); // R9
  AST_CARRY_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'd0) |=> (statusWord[POS_CARRY] == $past(carryOut)))
    else $error("carry mismatch"); // R1
endmodule

// File: tb/status_word_unit_tb_top.sv
module status_word_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, opValid, opWord, carryOut, nibbleCarry, ctlSet, ctlClr;
  logic [1:0] opClass, ctlSel;
  logic [15:0] operandA, operandB, result, statusWord;
  logic stepNeg;

  int vecCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  bit expCy, expPar, expAux, expZero, expSign, expOvf;
  bit [2:0] ctlModel;
  bit logicMode;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_word_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opWord(opWord), .opClass(opClass),
    .operandA(operandA), .operandB(operandB), .result(result),
    .carryOut(carryOut), .nibbleCarry(nibbleCarry), .ctlSel(ctlSel),
    .ctlSet(ctlSet), .ctlClr(ctlClr), .statusWord(statusWord), .stepNeg(stepNeg)
  );

  task automatic chk(string tag, string what, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string ovr);
    string tc = (ovr != "") ? ovr : (logicMode ? "R7" : "R1");
    string ta = (ovr != "") ? ovr : (logicMode ? "R7" : "R3");
    string to = (ovr != "") ? ovr : (logicMode ? "R7" : "R6");
    chk(tc, "carry", int'(statusWord[0]), int'(expCy));
    chk(ovr != "" ? ovr : "R2", "parity", int'(statusWord[2]), int'(expPar));
    chk(ta, "aux", int'(statusWord[4]), int'(expAux));
    chk(ovr != "" ? ovr : "R4", "zero", int'(statusWord[6]), int'(expZero));
    chk(ovr != "" ? ovr : "R5", "sign", int'(statusWord[7]), int'(expSign));
    chk(to, "overflow", int'(statusWord[11]), int'(expOvf));
    chk("R8", "fixed", int'({statusWord[15:12], statusWord[5], statusWord[3], statusWord[1]}), 1);
    chk(ovr != "" ? ovr : "R10", "control", int'(statusWord[10:8]), int'(ctlModel));
    chk("R12", "stepNeg", int'(stepNeg), int'(ctlModel[2]));
  endtask

  task automatic driveOp(int cls, bit word, int a, int b);
    int w = word ? 16 : 8;
    int mask = (1 << w) - 1;
    int half = 1 << (w - 1);
    int am = a & mask, bm = b & mask;
    int sa = (am >= half) ? am - 2 * half : am;
    int sb = (bm >= half) ? bm - 2 * half : bm;
    int res = 0, s = 0;
    bit cy = 0, nb = 0, ov = 0;
    logic [7:0] lo;
    case (cls)
      0: begin
        res = (am + bm) & mask; cy = (am + bm) > mask;
        nb = ((am & 15) + (bm & 15)) > 15; s = sa + sb;
        ov = (s > half - 1) || (s < -half);
      end
      1: begin
        res = (am - bm) & mask; cy = am < bm;
        nb = (am & 15) < (bm & 15); s = sa - sb;
        ov = (s > half - 1) || (s < -half);
      end
      default: res = am ^ bm;
    endcase
    opValid = 1'b1; opWord = word; opClass = 2'(cls);
    operandA = word ? 16'(am) : (16'h3C00 | 16'(am));
    operandB = word ? 16'(bm) : (16'hC300 | 16'(bm));
    result   = word ? 16'(res) : (16'hA500 | 16'(res));
    carryOut = (cls >= 2) ? 1'b1 : cy;
    nibbleCarry = (cls >= 2) ? 1'b1 : nb;
    lo = 8'(res);
    logicMode = (cls >= 2);
    expCy = cy; expAux = nb; expOvf = ov;
    expPar = ($countones(lo) % 2) == 0;
    expZero = (res == 0);
    expSign = ((res >> (w - 1)) & 1) != 0;
  endtask

  task automatic runOp(int cls, bit word, int a, int b);
    driveOp(cls, word, a, b);
    @(negedge clk);          // registered at the posedge in between (R14)
    opValid = 1'b0;
    checkAll("");
  endtask

  task automatic ctlCmd(int sel, bit s, bit c);
    ctlSel = 2'(sel); ctlSet = s; ctlClr = c;
    if (sel < 3 && (s || c)) ctlModel[sel] = s;
    @(negedge clk);
    ctlSet = 0; ctlClr = 0;
    checkAll("R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int words[12] = '{0, 1, 'h7FFF, 'h8000, 'hFFFF, 'h00FF, 'h0100, 'h1234,
                      'hFEDC, 'h0F0F, 'h8001, 'h7F80};
    rstN = 0; opValid = 0; opWord = 0; opClass = 0; operandA = 0; operandB = 0;
    result = 0; carryOut = 0; nibbleCarry = 0; ctlSel = 0; ctlSet = 0; ctlClr = 0;
    ctlModel = 0; logicMode = 0;
    repeat (2) @(negedge clk);
    chk("R13", "reset word", int'(statusWord), 'h0002);
    chk("R13", "reset stepNeg", int'(stepNeg), 0);
    rstN = 1;
    @(negedge clk);

    // byte sweep, every class
    for (int cls = 0; cls < 3; cls++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 15)
          runOp(cls, 1'b0, a, b);
    // code 3 behaves as logic (R7)
    runOp(3, 1'b0, 8'h80, 8'h01);
    // word boundaries
    for (int cls = 0; cls < 3; cls++)
      foreach (words[i])
        foreach (words[j])
          runOp(cls, 1'b1, words[i], words[j]);

    // idle hold with wild inputs (R11)
    runOp(0, 1'b1, 'h7FFF, 1);
    operandA = 16'hFFFF; operandB = 16'hFFFF; result = 16'h0000;
    carryOut = 1; nibbleCarry = 1; opClass = 2'd2;
    repeat (3) @(negedge clk);
    checkAll("R11");

    // control commands (R9, R12)
    ctlCmd(0, 1, 0);
    ctlCmd(1, 1, 0);
    ctlCmd(2, 1, 0);
    ctlCmd(0, 0, 1);
    ctlCmd(1, 1, 1);
    ctlCmd(2, 1, 1);
    ctlCmd(3, 1, 0);
    ctlCmd(3, 0, 1);
    ctlCmd(2, 0, 1);
    ctlCmd(2, 1, 0);

    // operation together with command (R10)
    driveOp(1, 1'b1, 'h8000, 1);
    ctlSel = 2'd0; ctlSet = 1; ctlModel[0] = 1;
    @(negedge clk);
    opValid = 0; ctlSet = 0;
    checkAll("R10");
    runOp(2, 1'b1, 'hFFFF, 'hFFFF);
    runOp(0, 1'b0, 'hFF, 1);

    // reset mid-run (R13)
    rstN = 0;
    @(negedge clk);
    chk("R13", "reset word", int'(statusWord), 'h0002);
    chk("R13", "reset stepNeg", int'(stepNeg), 0);
    rstN = 1; ctlModel = 0;
    runOp(1, 1'b0, 0, 1);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule